// File: doc/BRIEF.md
# Two-Wire Programming Link Host Engine

This block is the host end of a two-wire serial link to the program loaded on a target device for in-system programming. The host always drives the clock line. The data line is shared and changes direction during each transaction. A transaction starts when the upstream logic hands over three values: how many command words to send, how many response words to expect, and a timeout budget. The engine then sends the command words, each 16 bits, most significant bit first. It pulls each command word from a valid/ready stream and holds the clock low whenever the next word is not yet offered.

After the last command bit the engine stops driving the data line and waits for the target's handshake. The target holds the line high while it is busy and pulls it low when its answer is ready. The engine then waits a fixed settle interval and clocks in exactly the number of response bits expected. It passes each received word upstream through a one-word valid/ready output. Between words, and after the transaction, the clock is parked low.

A transaction can take too long for any reason, such as a target that never answers or an upstream side that stalls. In that case the engine abandons the transaction. It parks the link, raises a fault flag and pulses the target reset line.

Top module: `prog_link_host`

## Requirements
- R1: Out of reset the engine is idle: `cmd_ready`=1, `busy`=0, `fault`=0, `rx_valid`=0, and `pclk_o`, `pdat_oe` and `tgt_rst_o` are all 0. A command is taken only when `cmd_valid` is high while `cmd_ready` is high. From the cycle after that, `busy`=1 and `cmd_ready`=0 until the transaction ends.
- R2: Command words are sent 16 bits each, most significant bit first. `pdat_o` changes only while `pclk_o` is low and stays stable for the whole high phase, so the target captures each bit on the rising edge. `pdat_oe` is 1 while command bits are sent.
- R3: The high and low phases of `pclk_o` each last at least HALF system cycles, where HALF = ceil(CLK_HZ / (2·SCLK_MAX_HZ)). This keeps the link clock at or below SCLK_MAX_HZ. `pclk_o` is 0 whenever the engine is idle or waiting for a word.
- R4: After the last command bit, `pdat_oe` returns to 0. No `pclk_o` rising edge occurs until the response phase begins.
- R5: `pdat_i` passes through a two-stage synchronizer. A low level counts as the ready handshake only after the synchronized line has been seen high at least once since the command ended. A line that is already low at that point is not taken as ready.
- R6: The first response rising edge of `pclk_o` comes at least SETTLE_CYC = ceil(CLK_HZ·SETTLE_NS / 10^9) system cycles after `pdat_i` falls for the ready handshake.
- R7: The response phase produces exactly 16·`rsp_words` rising edges. Response bits are taken most significant bit first, and each word is presented on `rx_data` with `rx_valid` until `rx_ready`. The clock does not start the next word while the previous one is still unread, so no word is lost.
- R8: With `rsp_words`=0, the transaction ends after the settle interval with no response clock edges, and `busy` returns to 0.
- R9: Let L be the loaded `tmo_cycles` value. If the transaction is still running L+1 cycles after acceptance, it is aborted. `tgt_rst_o` rises in that cycle and stays high for RST_CYC cycles. At the same time `fault` goes to 1 and `pclk_o` and `pdat_oe` go to 0. `busy` remains 1 until the reset pulse ends. A transaction that completes earlier causes no reset.
- R10: `fault` stays 1 after a timeout and clears when the next command is accepted.
- R11: Command words arrive on `tx_data` with `tx_valid`/`tx_ready`. One word is taken per handshake, and gaps in `tx_valid` only stretch the low clock level between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start request for a transaction |
| cmd_ready | output | 1 | Engine idle, start request can be taken |
| cmd_words | input | CNT_W | Number of command words |
| rsp_words | input | CNT_W | Number of response words |
| tmo_cycles | input | TO_W | Timeout budget in system cycles |
| tx_valid | input | 1 | Command word offered |
| tx_ready | output | 1 | Engine takes the offered command word |
| tx_data | input | 16 | Command word |
| rx_valid | output | 1 | Response word available |
| rx_ready | input | 1 | Upstream takes the response word |
| rx_data | output | 16 | Response word |
| busy | output | 1 | Transaction in progress |
| fault | output | 1 | Last transaction timed out |
| pclk_o | output | 1 | Link clock to target |
| pdat_o | output | 1 | Link data driven to target |
| pdat_oe | output | 1 | Output enable for link data |
| pdat_i | input | 1 | Link data seen from target |
| tgt_rst_o | output | 1 | Target reset pulse |

## Verification
A phase counter that wraps at the wrong point shows up within one bit time. The link clock then gets a phase shorter than HALF, or a word is captured with a wrong bit count. A wrong direction or handshake state shows up in two ways. The data enable may stay high after the command, or clock edges may appear before the ready low plus the settle interval, and both can be seen in the turnaround of the same transaction. Errors in the word counters or the timeout counter appear only at the end of a transaction. They show as a wrong number of response edges, a lost or repeated word on the response stream, or a reset pulse that starts at the wrong cycle, lasts the wrong length, or appears when no timeout occurred.

// File: rtl/prog_link_host.sv
module prog_link_host #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SCLK_MAX_HZ = 1_000_000,
  parameter int SETTLE_NS   = 20_000,
  parameter int WORD_W      = 16,
  parameter int CNT_W       = 4,
  parameter int TO_W        = 24,
  parameter int RST_CYC     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CNT_W-1:0]  cmd_words,
  input  logic [CNT_W-1:0]  rsp_words,
  input  logic [TO_W-1:0]   tmo_cycles,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              fault,
  output logic              pclk_o,
  output logic              pdat_o,
  output logic              pdat_oe,
  input  logic              pdat_i,
  output logic              tgt_rst_o
);
  localparam int HALF = (CLK_HZ + 2*SCLK_MAX_HZ - 1) / (2*SCLK_MAX_HZ);
  localparam longint SETTLE_L = (longint'(CLK_HZ) * longint'(SETTLE_NS) + 64'd999_999_999) / 64'd1_000_000_000;
  localparam int SETTLE_CYC = (SETTLE_L < 1) ? 1 : int'(SETTLE_L);
  localparam int DIV_W = $clog2(HALF + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int RST_W = $clog2(RST_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_TXW, S_TXB, S_TURN, S_SETTLE, S_RXW, S_RXB, S_RST} st_t;
  st_t st;

  logic [DIV_W-1:0]  div;
  logic              ph;
  logic [BIT_W-1:0]  bitn;
  logic [CNT_W-1:0]  cmd_left, rsp_left;
  logic [TO_W-1:0]   tmo_lim, tmo_cnt;
  logic [WORD_W-1:0] sh;
  logic [1:0]        sync;
  logic              seen_hi;
  logic [SET_W-1:0]  set_cnt;
  logic [RST_W-1:0]  rst_cnt;

  wire din      = sync[1];
  wire ph_end   = (div == DIV_W'(HALF - 1));
  wire bit_last = (bitn == BIT_W'(WORD_W - 1));
  wire shifting = (st == S_TXB) || (st == S_RXB);
  wire active   = (st != S_IDLE) && (st != S_RST);
  wire tmo_hit  = active && (tmo_cnt == tmo_lim);

  assign cmd_ready = (st == S_IDLE);
  assign tx_ready  = (st == S_TXW);
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; ph <= 1'b0; bitn <= '0;
      cmd_left <= '0; rsp_left <= '0; tmo_lim <= '0; tmo_cnt <= '0;
      sh <= '0; sync <= 2'b11; seen_hi <= 1'b0; set_cnt <= '0; rst_cnt <= '0;
      rx_valid <= 1'b0; rx_data <= '0; fault <= 1'b0;
      pclk_o <= 1'b0; pdat_o <= 1'b0; pdat_oe <= 1'b0; tgt_rst_o <= 1'b0;
    end else begin
      sync <= {sync[0], pdat_i};
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (active) tmo_cnt <= tmo_cnt + TO_W'(1);
      if (shifting) div <= ph_end ? '0 : div + DIV_W'(1);
      if (tmo_hit) begin
        st <= S_RST; pclk_o <= 1'b0; pdat_oe <= 1'b0;
        tgt_rst_o <= 1'b1; fault <= 1'b1; rst_cnt <= '0;
      end else begin
        case (st)
          S_IDLE: if (cmd_valid) begin
            cmd_left <= cmd_words; rsp_left <= rsp_words;
            tmo_lim <= tmo_cycles; tmo_cnt <= '0;
            fault <= 1'b0; seen_hi <= 1'b0;
            st <= (cmd_words == '0) ? S_TURN : S_TXW;
          end
          S_TXW: if (tx_valid) begin
            sh <= tx_data; pdat_o <= tx_data[WORD_W-1]; pdat_oe <= 1'b1;
            div <= '0; ph <= 1'b0; bitn <= '0; st <= S_TXB;
          end
          S_TXB: if (ph_end) begin
            if (!ph) begin
              ph <= 1'b1; pclk_o <= 1'b1;
            end else begin
              ph <= 1'b0; pclk_o <= 1'b0;
              if (bit_last) begin
                cmd_left <= cmd_left - CNT_W'(1);
                if (cmd_left == CNT_W'(1)) begin
                  st <= S_TURN; pdat_oe <= 1'b0; seen_hi <= 1'b0;
                end else begin
                  st <= S_TXW;
                end
              end else begin
                bitn <= bitn + BIT_W'(1);
                sh <= {sh[WORD_W-2:0], 1'b0};
                pdat_o <= sh[WORD_W-2];
              end
            end
          end
          S_TURN: begin
            if (din) seen_hi <= 1'b1;
            else if (seen_hi) begin st <= S_SETTLE; set_cnt <= '0; end
          end
          S_SETTLE: begin
            if (set_cnt == SET_W'(SETTLE_CYC - 1)) st <= (rsp_left == '0) ? S_IDLE : S_RXW;
            else set_cnt <= set_cnt + SET_W'(1);
          end
          S_RXW: if (!rx_valid) begin
            div <= '0; ph <= 1'b0; bitn <= '0; st <= S_RXB;
          end
          S_RXB: if (ph_end) begin
            if (!ph) begin
              ph <= 1'b1; pclk_o <= 1'b1;
            end else begin
              ph <= 1'b0; pclk_o <= 1'b0;
              sh <= {sh[WORD_W-2:0], din};
              if (bit_last) begin
                rx_data <= {sh[WORD_W-2:0], din}; rx_valid <= 1'b1;
                rsp_left <= rsp_left - CNT_W'(1);
                st <= (rsp_left == CNT_W'(1)) ? S_IDLE : S_RXW;
              end else begin
                bitn <= bitn + BIT_W'(1);
              end
            end
          end
          S_RST: begin
            if (rst_cnt == RST_W'(RST_CYC - 1)) begin tgt_rst_o <= 1'b0; st <= S_IDLE; end
            else rst_cnt <= rst_cnt + RST_W'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !pclk_o); // R3
  AST_PHASE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) !$stable(pclk_o) |-> ($past(ph_end) || $past(tmo_hit))); // R3
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (pclk_o && $past(pclk_o)) |-> $stable(pdat_o)); // R2
  AST_RELEASED_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n) (st inside {S_TURN, S_SETTLE, S_RXW, S_RXB}) |-> !pdat_oe); // R4
  AST_SETTLE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (st == S_SETTLE && $past(st) == S_TURN) |-> $past(seen_hi)); // R5
  AST_RST_PARKED: assert property (@(posedge clk) disable iff (!rst_n) tgt_rst_o |-> (fault && !pclk_o && !pdat_oe)); // R9
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) active |-> (tmo_cnt <= tmo_lim)); // R9
endmodule

// File: tb/sim_prog_link_host.sv
module sim_prog_link_host;
  localparam int CLK_HZ = 100_000_000;
  localparam int SCLK_HZ = 10_000_000;
  localparam int SETTLE_NS = 2000;
  localparam int RST_CYC = 8;
  localparam int CNT_W = 3;
  localparam int TO_W = 16;
  localparam int HALF_E = 5;
  localparam int SETTLE_E = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, tx_valid = 0, tx_ready, rx_valid, rx_ready = 0;
  logic [CNT_W-1:0] cmd_words = '0, rsp_words = '0;
  logic [TO_W-1:0] tmo_cycles = '0;
  logic [15:0] tx_data = '0, rx_data;
  logic busy, fault, pclk_o, pdat_o, pdat_oe, tgt_rst_o;
  logic tgt_d = 1'b1;

  prog_link_host #(.CLK_HZ(CLK_HZ), .SCLK_MAX_HZ(SCLK_HZ), .SETTLE_NS(SETTLE_NS),
    .WORD_W(16), .CNT_W(CNT_W), .TO_W(TO_W), .RST_CYC(RST_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_words(cmd_words), .rsp_words(rsp_words), .tmo_cycles(tmo_cycles),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .busy(busy), .fault(fault), .pclk_o(pclk_o), .pdat_o(pdat_o), .pdat_oe(pdat_oe),
    .pdat_i(tgt_d), .tgt_rst_o(tgt_rst_o));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  logic prev_clk = 0, prev_rst = 0;
  int run = 0, min_run = 1000000;
  logic [15:0] cap_sh = '0;
  logic [15:0] cap_w [8];
  int cap_bits = 0, cap_n = 0, rsp_edges = 0, rise1 = -1;
  bit tgt_on = 0;
  logic [15:0] tgt_w [8];
  int tgt_nr = 0, tgt_bit = 0, tgt_idx = 0;
  int rst_rise = -1, rst_len = 0;

  always @(negedge clk) begin
    if (pclk_o != prev_clk) begin
      if (run < min_run) min_run = run;
      run = 1;
    end else run++;
    if (pclk_o && !prev_clk) begin
      if (pdat_oe) begin
        cap_sh = {cap_sh[14:0], pdat_o};
        cap_bits++;
        if (cap_bits == 16) begin
          if (cap_n < 8) cap_w[cap_n] = cap_sh;
          cap_n++;
          cap_bits = 0;
        end
      end else begin
        if (rsp_edges == 0) rise1 = cyc;
        rsp_edges++;
      end
    end
    if (!pclk_o && prev_clk && tgt_on) begin
      tgt_bit++;
      if (tgt_bit == 16) begin tgt_bit = 0; tgt_idx++; end
      tgt_d = (tgt_idx < tgt_nr) ? tgt_w[tgt_idx][15-tgt_bit] : 1'b1;
    end
    if (tgt_rst_o) begin
      if (!prev_rst) rst_rise = cyc;
      rst_len++;
    end
    prev_rst = tgt_rst_o;
    prev_clk = pclk_o;
  end

  task automatic run_txn(input int nc, input int nr, input int rdy_dly,
                         input bit start_low, input bit no_rdy, input int tmo);
    logic [15:0] cw [8];
    logic [15:0] got [8];
    int acc, r, edges_at_rdy, k;
    r = -1; edges_at_rdy = -1; k = 0;
    for (int i = 0; i < 8; i++) begin
      cw[i] = 16'($urandom);
      tgt_w[i] = 16'($urandom);
      got[i] = '0;
    end
    while (!cmd_ready) @(negedge clk);
    cap_n = 0; cap_bits = 0; rsp_edges = 0; rise1 = -1; min_run = 1000000;
    rst_rise = -1; rst_len = 0;
    tgt_on = 0; tgt_nr = nr; tgt_bit = 0; tgt_idx = 0;
    tgt_d = start_low ? 1'b0 : 1'b1;
    cmd_words = CNT_W'(nc); rsp_words = CNT_W'(nr); tmo_cycles = TO_W'(tmo);
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    acc = cyc;
    chk(busy && !cmd_ready, "R1 busy and not ready after accept", {busy, cmd_ready}, 2);
    chk(!fault, "R10 fault cleared on accept", fault, 0);
    fork
      begin
        for (int i = 0; i < nc; i++) begin
          tx_valid = 0;
          repeat ($urandom % 4) @(negedge clk);
          tx_valid = 1; tx_data = cw[i];
          while (!tx_ready) @(negedge clk);
          @(negedge clk);
        end
        tx_valid = 0;
      end
      begin
        while (!pdat_oe) @(negedge clk);
        while (pdat_oe) @(negedge clk);
        if (start_low) begin repeat (40) @(negedge clk); tgt_d = 1'b1; end
        if (!no_rdy) begin
          repeat (rdy_dly) @(negedge clk);
          tgt_d = 1'b0; r = cyc; edges_at_rdy = rsp_edges;
          repeat (10) @(negedge clk);
          tgt_d = (nr > 0) ? tgt_w[0][15] : 1'b1;
          tgt_on = 1;
        end
      end
      begin
        if (!no_rdy) begin
          while (k < nr) begin
            @(negedge clk);
            rx_ready = 1'($urandom);
            if (rx_valid && rx_ready) begin got[k] = rx_data; k++; end
          end
          @(negedge clk);
          rx_ready = 0;
        end
      end
    join
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    if (no_rdy) begin
      chk(rst_rise - acc == tmo + 1, "R9 reset starts at timeout", rst_rise - acc, tmo + 1);
      chk(rst_len == RST_CYC, "R9 reset pulse length", rst_len, RST_CYC);
      chk(fault, "R9 fault raised", fault, 1);
      chk(rsp_edges == 0 && !pclk_o && !pdat_oe, "R9 link parked", rsp_edges, 0);
    end else begin
      chk(edges_at_rdy == 0, "R4 no clock edges before ready", edges_at_rdy, 0);
      chk(rst_rise == -1 && !fault, "R9 no reset without timeout", rst_rise, -1);
      chk(rsp_edges == 16*nr, nr == 0 ? "R8 no response edges" : "R7 response edge count",
          rsp_edges, 16*nr);
      if (nr > 0) begin
        chk(rise1 - r >= SETTLE_E, start_low ? "R5 initial low not taken as ready" : "R6 settle delay",
            rise1 - r, SETTLE_E);
        for (int i = 0; i < nr; i++)
          chk(got[i] == tgt_w[i], "R7 response word", got[i], tgt_w[i]);
      end
    end
    chk(cap_n == nc && cap_bits == 0, "R2 command word count", cap_n, nc);
    for (int i = 0; i < nc; i++)
      chk(cap_w[i] == cw[i], "R2/R11 command word msb first", cap_w[i], cw[i]);
    chk(min_run >= HALF_E, "R3 minimum clock phase", min_run, HALF_E);
    chk(!pclk_o && cmd_ready && !busy, "R3 clock parked low when idle", pclk_o, 0);
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !busy && !fault && !rx_valid && !pclk_o && !pdat_oe && !tgt_rst_o,
        "R1 reset state", {cmd_ready, busy, fault, rx_valid, pclk_o, pdat_oe, tgt_rst_o}, 7'b1000000);
    run_txn(1, 1, 20, 0, 0, 20000);
    run_txn(2, 0, 5, 0, 0, 20000);
    run_txn(1, 2, 30, 1, 0, 20000);
    run_txn(1, 0, 0, 0, 1, 600);
    run_txn(3, 3, 0, 0, 0, 30000);
    for (int t = 0; t < 10; t++)
      run_txn(1 + int'($urandom % 3), int'($urandom % 4), int'($urandom % 60), 0, 0, 30000);
    run_txn(2, 0, 0, 0, 1, 700 + int'($urandom % 200));
    run_txn(2, 2, 15, 0, 0, 30000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule